// File: doc/BRIEF.md
# Region Protection Configuration Register File

This block is the register file behind a physical memory protection unit. It stores one configuration byte and one address register for each protected region, plus a small machine security register. Software reaches the file through a single CSR access port. A write carries a register kind, an index and a data word, and a combinational read returns the word that the kind and index select. Configuration bytes are packed into CSR words, several regions per word. Each configuration write is checked byte by byte against the lock rules before it is stored.

The lock rules follow one base scheme and one extended scheme. The `extMode` input selects the scheme. In the base scheme a locked region refuses further configuration writes. In the extended scheme a rule-lock bypass bit can lift every lock. When the machine lockdown bit is set, the value being written decides whether the write is taken, not the current lock. Address writes are refused when the region is locked. They are also refused when the next region is locked in top-of-range mode, because that region uses this address as its base.

The raw configuration bytes, the address registers and the security bits are exported as flat vectors to the region decoder. A one-cycle flush pulse follows every configuration write, whether the write was taken or refused, so that cached permission results can be dropped.

Top module: `pmp_csr_file`

## Requirements
- R1: A synchronous active-high reset clears every configuration byte, every address register, the security register and the flush pulse.
- R2: Configuration byte bit 7 is the lock L, bits 4:3 are the match mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 2 is X, bit 1 is W and bit 0 is R. Byte i of configuration word k (kind 0) belongs to region 4k+i, on both writes and reads.
- R3: A configuration or address write that targets a region index of 16 or more changes nothing. Read lanes for such regions return zero.
- R4: An address write (kind 1) to a region whose L bit is set is ignored.
- R5: An address write to region n is ignored when region n+1 has L set and match mode 1. Otherwise it is taken.
- R6: With `extMode` low, each configuration byte is stored only if the target region's current L bit is clear.
- R7: With `extMode` high and the bypass bit set, every configuration byte is stored, locked regions included.
- R8: With `extMode` high and both bypass and lockdown clear, a byte is stored only if the region's current L bit is clear.
- R9: With `extMode` high, lockdown set and bypass clear, a byte is stored exactly when it has L set and X clear, or when it has L clear and bits 2:0 are not 3'b110. The region's current lock does not matter.
- R10: The lockdown and whitelist bits of the security register are sticky. Once set, no write clears them.
- R11: The bypass bit stays clear on a write while it is clear and any region has L set. Otherwise it takes bit 2 of the written word.
- R12: The security register (kind 2) holds lockdown in bit 0, whitelist policy in bit 1 and bypass in bit 2. All other read bits are zero.
- R13: `flushPulse` is high for exactly the one cycle after each configuration write, taken or not, and is low otherwise.
- R14: `cfgOut` carries region r's byte at bits 8r+7:8r. `addrOut` carries region r's address at bits XLEN*(r+1)-1:XLEN*r. `secOut` mirrors the three security bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| extMode | input | 1 | Selects the extended lock scheme |
| csrWr | input | 1 | Write strobe for the access in this cycle |
| csrKind | input | 2 | 0 configuration word, 1 address, 2 security, 3 none |
| csrIdx | input | IDX_W | Word or region index |
| csrWdata | input | XLEN | Write data |
| csrRdata | output | XLEN | Read data for kind and index, combinational |
| cfgOut | output | NUM_REGIONS*8 | All configuration bytes |
| addrOut | output | NUM_REGIONS*XLEN | All address registers |
| secOut | output | 3 | Lockdown, whitelist, bypass (bits 0, 1, 2) |
| flushPulse | output | 1 | One-cycle pulse after a configuration write |

## Verification
The bench targets the neighbour rule. An address write just below a locked top-of-range region must be refused, while one below an unlocked, off-mode region must be taken. A design that looked only at its own lock would let the base of a locked range move. Mixed-byte configuration words check that the lock decision is made per byte: a design that judged the whole word would either drop the open neighbours of a locked byte or overwrite the locked byte. Under lockdown the bench writes a locked-readable byte over a locked region, a locked executable byte, a write-execute-only byte and a plain read-write byte in one word. A wrong acceptance rule would store the wrong subset of those bytes. Further checks cover the sticky security bits, the refused bypass set while a lock exists, and out-of-range indices, where a design that dropped the bound check would alias another region.

// File: rtl/pmp_csr_pkg.sv
package pmp_csr_pkg;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_SEC  = 2'd2,
    KIND_NONE = 2'd3
  } csrKind_e;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_NA4   = 2'd2,
    MATCH_NAPOT = 2'd3
  } matchMode_e;

  // bit positions inside one configuration byte
  localparam int unsigned CFG_LOCK_BIT = 7;
  localparam int unsigned CFG_MODE_LO  = 3;

  // bit positions inside the security register
  localparam int unsigned SEC_LOCKDOWN = 0;
  localparam int unsigned SEC_WHITELIST = 1;
  localparam int unsigned SEC_BYPASS   = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgWr;    // a configuration write happened (drives the flush)
    logic addrWr;   // accepted address write to csrIdx
    logic secWr;    // security register write
    logic bypassOk; // bypass bit may take the written value
  } strobe_t;

endpackage

// File: rtl/pmp_csr_ctrl.sv
module pmp_csr_ctrl
  import pmp_csr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 16,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned IDX_W       = 8
) (
  input  logic                     csrWr,
  input  logic [1:0]               csrKind,
  input  logic [IDX_W-1:0]         csrIdx,
  input  logic [XLEN-1:0]          csrWdata,
  input  logic                     extMode,
  input  logic [NUM_REGIONS-1:0]   lockVec,
  input  logic [NUM_REGIONS-1:0]   torVec,
  input  logic                     secLockdown,
  input  logic                     secBypass,
  output strobe_t                  stb,
  output logic [NUM_REGIONS-1:0]   cfgByteEn,
  output logic [NUM_REGIONS*8-1:0] cfgNext
);

  localparam int unsigned BYTES_PER_WORD = XLEN / 8;
  localparam int unsigned LANE_W = (BYTES_PER_WORD > 1) ? $clog2(BYTES_PER_WORD) : 1;

  logic        wrCfg;
  logic        wrAddr;
  logic        wrSec;
  logic [31:0] baseRegion;

  assign wrCfg      = csrWr && (csrKind == KIND_CFG);
  assign wrAddr     = csrWr && (csrKind == KIND_ADDR);
  assign wrSec      = csrWr && (csrKind == KIND_SEC);
  assign baseRegion = 32'(csrIdx) << 2;

  // per-region acceptance of a configuration byte
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cfgLane
    logic [31:0]       offs;
    logic              inWord;
    logic [LANE_W-1:0] lane;
    logic              newLock;
    logic [2:0]        newXwr;
    logic              lockdownOk;
    logic              accept;

    assign offs    = 32'(r) - baseRegion;
    assign inWord  = (32'(r) >= baseRegion) && (offs < 32'(BYTES_PER_WORD));
    assign lane    = offs[LANE_W-1:0];
    assign newLock = csrWdata[{lane, 3'b111}];
    assign newXwr  = csrWdata[{lane, 3'b000} +: 3];

    assign lockdownOk = (newLock && !newXwr[2]) || (!newLock && (newXwr != 3'b110));

    always_comb begin
      if (!extMode) begin
        accept = !lockVec[r];
      end else begin
        accept = secBypass
              || (!secLockdown && !lockVec[r])
              || (secLockdown && lockdownOk);
      end
    end

    assign cfgByteEn[r]      = wrCfg && inWord && accept;
    assign cfgNext[r*8 +: 8] = csrWdata[{lane, 3'b000} +: 8];
  end

  // address write guards: own lock and locked top-of-range neighbour
  logic idxInRange;
  logic selfLocked;
  logic nextLockedTor;
  logic anyLocked;

  assign idxInRange = 32'(csrIdx) < 32'(NUM_REGIONS);

  always_comb begin
    selfLocked    = 1'b0;
    nextLockedTor = 1'b0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (32'(csrIdx) == 32'(r)) begin
        selfLocked = lockVec[r];
      end
      if (32'(csrIdx) + 32'd1 == 32'(r)) begin
        nextLockedTor = lockVec[r] && torVec[r];
      end
    end
  end

  assign anyLocked = |lockVec;

  always_comb begin
    stb          = '0;
    stb.cfgWr    = wrCfg;
    stb.addrWr   = wrAddr && idxInRange && !selfLocked && !nextLockedTor;
    stb.secWr    = wrSec;
    stb.bypassOk = secBypass || !anyLocked;
  end

endmodule

// File: rtl/pmp_csr_dp.sv
module pmp_csr_dp
  import pmp_csr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 16,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned IDX_W       = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  strobe_t                     stb,
  input  logic [NUM_REGIONS-1:0]      cfgByteEn,
  input  logic [NUM_REGIONS*8-1:0]    cfgNext,
  input  logic [1:0]                  csrKind,
  input  logic [IDX_W-1:0]            csrIdx,
  input  logic [XLEN-1:0]             csrWdata,
  output logic [XLEN-1:0]             csrRdata,
  output logic [NUM_REGIONS*8-1:0]    cfgQ,
  output logic [NUM_REGIONS*XLEN-1:0] addrQ,
  output logic [NUM_REGIONS-1:0]      lockVec,
  output logic [NUM_REGIONS-1:0]      torVec,
  output logic                        lockdownQ,
  output logic                        whitelistQ,
  output logic                        bypassQ,
  output logic                        flushQ
);

  localparam int unsigned BYTES_PER_WORD = XLEN / 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ       <= '0;
      addrQ      <= '0;
      lockdownQ  <= 1'b0;
      whitelistQ <= 1'b0;
      bypassQ    <= 1'b0;
      flushQ     <= 1'b0;
    end else begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (cfgByteEn[r]) begin
          cfgQ[r*8 +: 8] <= cfgNext[r*8 +: 8];
        end
        if (stb.addrWr && (32'(csrIdx) == 32'(r))) begin
          addrQ[r*XLEN +: XLEN] <= csrWdata;
        end
      end
      if (stb.secWr) begin
        lockdownQ  <= lockdownQ  | csrWdata[SEC_LOCKDOWN];
        whitelistQ <= whitelistQ | csrWdata[SEC_WHITELIST];
        bypassQ    <= csrWdata[SEC_BYPASS] & stb.bypassOk;
      end
      flushQ <= stb.cfgWr;
    end
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_flags
    assign lockVec[r] = cfgQ[r*8 + CFG_LOCK_BIT];
    assign torVec[r]  = (cfgQ[r*8 + CFG_MODE_LO +: 2] == MATCH_TOR);
  end

  logic [31:0] baseRegion;
  assign baseRegion = 32'(csrIdx) << 2;

  always_comb begin
    csrRdata = '0;
    case (csrKind)
      KIND_CFG: begin
        for (int i = 0; i < BYTES_PER_WORD; i++) begin
          for (int r = 0; r < NUM_REGIONS; r++) begin
            if (baseRegion + 32'(i) == 32'(r)) begin
              csrRdata[i*8 +: 8] = cfgQ[r*8 +: 8];
            end
          end
        end
      end
      KIND_ADDR: begin
        for (int r = 0; r < NUM_REGIONS; r++) begin
          if (32'(csrIdx) == 32'(r)) begin
            csrRdata = addrQ[r*XLEN +: XLEN];
          end
        end
      end
      KIND_SEC: begin
        csrRdata[SEC_LOCKDOWN]  = lockdownQ;
        csrRdata[SEC_WHITELIST] = whitelistQ;
        csrRdata[SEC_BYPASS]    = bypassQ;
      end
      default: csrRdata = '0;
    endcase
  end

endmodule

// File: rtl/pmp_csr_file.sv
module pmp_csr_file
  import pmp_csr_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 16,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned IDX_W       = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        extMode,
  input  logic                        csrWr,
  input  logic [1:0]                  csrKind,
  input  logic [IDX_W-1:0]            csrIdx,
  input  logic [XLEN-1:0]             csrWdata,
  output logic [XLEN-1:0]             csrRdata,
  output logic [NUM_REGIONS*8-1:0]    cfgOut,
  output logic [NUM_REGIONS*XLEN-1:0] addrOut,
  output logic [2:0]                  secOut,
  output logic                        flushPulse
);

  strobe_t                  stb;
  logic [NUM_REGIONS-1:0]   cfgByteEn;
  logic [NUM_REGIONS*8-1:0] cfgNext;
  logic [NUM_REGIONS-1:0]   lockVec;
  logic [NUM_REGIONS-1:0]   torVec;
  logic                     lockdownQ;
  logic                     whitelistQ;
  logic                     bypassQ;

  pmp_csr_ctrl #(
    .NUM_REGIONS(NUM_REGIONS), .XLEN(XLEN), .IDX_W(IDX_W)
  ) i_ctrl (
    .csrWr      (csrWr),
    .csrKind    (csrKind),
    .csrIdx     (csrIdx),
    .csrWdata   (csrWdata),
    .extMode    (extMode),
    .lockVec    (lockVec),
    .torVec     (torVec),
    .secLockdown(lockdownQ),
    .secBypass  (bypassQ),
    .stb        (stb),
    .cfgByteEn  (cfgByteEn),
    .cfgNext    (cfgNext)
  );

  pmp_csr_dp #(
    .NUM_REGIONS(NUM_REGIONS), .XLEN(XLEN), .IDX_W(IDX_W)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .cfgByteEn (cfgByteEn),
    .cfgNext   (cfgNext),
    .csrKind   (csrKind),
    .csrIdx    (csrIdx),
    .csrWdata  (csrWdata),
    .csrRdata  (csrRdata),
    .cfgQ      (cfgOut),
    .addrQ     (addrOut),
    .lockVec   (lockVec),
    .torVec    (torVec),
    .lockdownQ (lockdownQ),
    .whitelistQ(whitelistQ),
    .bypassQ   (bypassQ),
    .flushQ    (flushPulse)
  );

  assign secOut = {bypassQ, whitelistQ, lockdownQ};

endmodule

// File: rtl/pmp_csr_checker.sv
module pmp_csr_checker #(
  parameter int unsigned NUM_REGIONS = 16,
  parameter int unsigned XLEN        = 32,
  parameter int unsigned IDX_W       = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        extMode,
  input logic                        csrWr,
  input logic [1:0]                  csrKind,
  input logic [IDX_W-1:0]            csrIdx,
  input logic [XLEN-1:0]             csrRdata,
  input logic [NUM_REGIONS*8-1:0]    cfgOut,
  input logic [NUM_REGIONS*XLEN-1:0] addrOut,
  input logic [2:0]                  secOut,
  input logic                        flushPulse
);

  logic [NUM_REGIONS-1:0] lockAt;
  logic                   selfLock;
  logic                   nextLockTor;
  logic                   idxIn;
  logic                   addrWrite;
  logic                   cfgWrite;
  logic                   rstQ;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_lock
    assign lockAt[r] = cfgOut[r*8 + 7];
  end

  always_comb begin
    selfLock    = 1'b0;
    nextLockTor = 1'b0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (32'(csrIdx) == 32'(r)) selfLock = lockAt[r];
      if (32'(csrIdx) + 32'd1 == 32'(r))
        nextLockTor = lockAt[r] && (cfgOut[r*8 + 3 +: 2] == 2'd1);
    end
  end

  assign idxIn     = 32'(csrIdx) < 32'(NUM_REGIONS);
  assign addrWrite = csrWr && (csrKind == 2'd1);
  assign cfgWrite  = csrWr && (csrKind == 2'd0);

  // R1: everything cleared the cycle after reset
  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rstQ) begin
      assert_reset_clear_R1: assert (cfgOut == '0 && addrOut == '0 && secOut == 3'b000 && !flushPulse)
        else $error("reset did not clear state");
    end
  end

  assert_addr_range_R3: assert property (@(posedge clk) disable iff (rst)
    (addrWrite && !idxIn) |=> $stable(addrOut));

  assert_addr_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (addrWrite && selfLock) |=> $stable(addrOut));

  assert_addr_tor_R5: assert property (@(posedge clk) disable iff (rst)
    (addrWrite && nextLockTor) |=> $stable(addrOut));

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_baseLock
    assert_base_lock_R6: assert property (@(posedge clk) disable iff (rst)
      (!extMode && lockAt[r]) |=> $stable(cfgOut[r*8 +: 8]));
  end

  assert_sticky_lockdown_R10: assert property (@(posedge clk) disable iff (rst)
    secOut[0] |=> secOut[0]);

  assert_sticky_whitelist_R10: assert property (@(posedge clk) disable iff (rst)
    secOut[1] |=> secOut[1]);

  assert_bypass_guard_R11: assert property (@(posedge clk) disable iff (rst)
    (!secOut[2] && (|lockAt)) |=> !secOut[2]);

  assert_sec_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (csrKind == 2'd2) |-> (csrRdata[XLEN-1:3] == '0));

  assert_flush_on_cfg_R13: assert property (@(posedge clk) disable iff (rst)
    cfgWrite |=> flushPulse);

  assert_flush_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    !cfgWrite |=> !flushPulse);

endmodule

bind pmp_csr_file pmp_csr_checker #(
  .NUM_REGIONS(NUM_REGIONS), .XLEN(XLEN), .IDX_W(IDX_W)
) i_checker (
  .clk       (clk),
  .rst       (rst),
  .extMode   (extMode),
  .csrWr     (csrWr),
  .csrKind   (csrKind),
  .csrIdx    (csrIdx),
  .csrRdata  (csrRdata),
  .cfgOut    (cfgOut),
  .addrOut   (addrOut),
  .secOut    (secOut),
  .flushPulse(flushPulse)
);

// File: tb/test_pmp_csr_file.sv
module test_pmp_csr_file;

  localparam int unsigned NUM_REGIONS = 16;
  localparam int unsigned XLEN        = 32;
  localparam int unsigned IDX_W       = 8;
  localparam int unsigned NVEC        = 12;

  logic                        clk = 1'b0;
  logic                        rst = 1'b1;
  logic                        extMode = 1'b0;
  logic                        csrWr = 1'b0;
  logic [1:0]                  csrKind = 2'd3;
  logic [IDX_W-1:0]            csrIdx = '0;
  logic [XLEN-1:0]             csrWdata = '0;
  logic [XLEN-1:0]             csrRdata;
  logic [NUM_REGIONS*8-1:0]    cfgOut;
  logic [NUM_REGIONS*XLEN-1:0] addrOut;
  logic [2:0]                  secOut;
  logic                        flushPulse;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic flushSeen;

  always #10 clk = ~clk;

  pmp_csr_file #(
    .NUM_REGIONS(NUM_REGIONS), .XLEN(XLEN), .IDX_W(IDX_W)
  ) i_pmp_csr_file (
    .clk(clk), .rst(rst), .extMode(extMode), .csrWr(csrWr),
    .csrKind(csrKind), .csrIdx(csrIdx), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .cfgOut(cfgOut), .addrOut(addrOut),
    .secOut(secOut), .flushPulse(flushPulse)
  );

  // vector: kind[73:72] idx[71:64] wdata[63:32] expected readback[31:0]
  localparam logic [73:0] VEC [NVEC] = '{
    {2'd0, 8'd0,  32'h4433_2211, 32'h4433_2211},
    {2'd1, 8'd5,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {2'd0, 8'd3,  32'h8C00_0000, 32'h8C00_0000},
    {2'd1, 8'd14, 32'h1234_5678, 32'h0000_0000},
    {2'd1, 8'd15, 32'h0000_0055, 32'h0000_0000},
    {2'd0, 8'd3,  32'h0000_0000, 32'h8C00_0000},
    {2'd0, 8'd3,  32'h0007_0605, 32'h8C07_0605},
    {2'd0, 8'd4,  32'hFFFF_FFFF, 32'h0000_0000},
    {2'd1, 8'd16, 32'hFFFF_FFFF, 32'h0000_0000},
    {2'd2, 8'd0,  32'h0000_0004, 32'h0000_0000},
    {2'd2, 8'd0,  32'hFFFF_FFF8, 32'h0000_0000},
    {2'd1, 8'd13, 32'h0000_ABCD, 32'h0000_ABCD}
  };
  localparam string VEC_REQ [NVEC] = '{
    "R2", "R14", "R2", "R5", "R4", "R6", "R6", "R3", "R3", "R11", "R12", "R5"
  };

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] kind, input logic [IDX_W-1:0] idx, input logic [XLEN-1:0] data);
    @(negedge clk);
    csrWr = 1'b1; csrKind = kind; csrIdx = idx; csrWdata = data;
    @(negedge clk);
    csrWr = 1'b0;
    flushSeen = flushPulse;
  endtask

  task automatic rd(input logic [1:0] kind, input logic [IDX_W-1:0] idx, output logic [XLEN-1:0] val);
    @(negedge clk);
    csrWr = 1'b0; csrKind = kind; csrIdx = idx;
    #1;
    val = csrRdata;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [XLEN-1:0] v;
    logic [XLEN-1:0] acc;

    doReset();

    // R1: reset state through the ports and the read path
    acc = '0;
    for (int k = 0; k < 4; k++) begin
      rd(2'd0, 8'(k), v);
      acc |= v;
    end
    check("R1", acc, '0);
    acc = '0;
    for (int k = 0; k < NUM_REGIONS; k++) begin
      rd(2'd1, 8'(k), v);
      acc |= v;
    end
    check("R1", acc, '0);
    rd(2'd2, 8'd0, v);
    check("R1", v, '0);
    check("R1", {31'd0, flushPulse}, 32'd0);
    check("R1", {31'd0, (cfgOut != '0) || (addrOut != '0)}, 32'd0);

    // vector table, base lock scheme
    for (int n = 0; n < NVEC; n++) begin
      wr(VEC[n][73:72], VEC[n][71:64], VEC[n][63:32]);
      rd(VEC[n][73:72], VEC[n][71:64], v);
      check(VEC_REQ[n], v, VEC[n][31:0]);
    end

    // R3: the out-of-range config write did not alias word 0
    rd(2'd0, 8'd0, v);
    check("R3", v, 32'h4433_2211);

    // R14: exported vectors
    check("R14", {24'd0, cfgOut[15*8 +: 8]}, 32'h0000_008C);
    check("R14", {24'd0, cfgOut[13*8 +: 8]}, 32'h0000_0006);
    check("R14", addrOut[5*XLEN +: XLEN], 32'hDEAD_BEEF);
    check("R14", addrOut[13*XLEN +: XLEN], 32'h0000_ABCD);
    check("R14", {29'd0, secOut}, 32'd0);

    // R13: flush after a refused config write, then drop; none after an address write
    wr(2'd0, 8'd3, 32'h0000_0000);
    check("R13", {31'd0, flushSeen}, 32'd1);
    @(negedge clk);
    check("R13", {31'd0, flushPulse}, 32'd0);
    wr(2'd1, 8'd2, 32'h0000_0001);
    check("R13", {31'd0, flushSeen}, 32'd0);

    // extended scheme
    doReset();
    extMode = 1'b1;

    wr(2'd2, 8'd0, 32'h0000_0004);
    rd(2'd2, 8'd0, v);
    check("R11", v, 32'h0000_0004);

    wr(2'd0, 8'd0, 32'h0000_0080);
    rd(2'd0, 8'd0, v);
    check("R7", v, 32'h0000_0080);
    wr(2'd0, 8'd0, 32'h0000_0000);
    rd(2'd0, 8'd0, v);
    check("R7", v, 32'h0000_0000);
    wr(2'd0, 8'd0, 32'h0000_0080);

    wr(2'd2, 8'd0, 32'h0000_0000);
    rd(2'd2, 8'd0, v);
    check("R11", v, 32'h0000_0000);
    wr(2'd2, 8'd0, 32'h0000_0004);
    rd(2'd2, 8'd0, v);
    check("R11", v, 32'h0000_0000);

    wr(2'd0, 8'd0, 32'h0000_0000);
    rd(2'd0, 8'd0, v);
    check("R8", v, 32'h0000_0080);

    wr(2'd2, 8'd0, 32'h0000_0001);
    wr(2'd2, 8'd0, 32'h0000_0000);
    rd(2'd2, 8'd0, v);
    check("R10", v, 32'h0000_0001);
    wr(2'd2, 8'd0, 32'h0000_0002);
    wr(2'd2, 8'd0, 32'h0000_0000);
    rd(2'd2, 8'd0, v);
    check("R10", v, 32'h0000_0003);

    // R9: lockdown, value-based acceptance per byte
    wr(2'd0, 8'd0, 32'h0306_8481);
    rd(2'd0, 8'd0, v);
    check("R9", v, 32'h0300_0081);
    wr(2'd0, 8'd0, 32'h0000_0007);
    rd(2'd0, 8'd0, v);
    check("R9", v, 32'h0000_0007);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule